// File: doc/BRIEF.md
# Circular Queue Pointer Unit

This block keeps the producer and consumer pointers of a ring buffer that lives in system memory, such as the command ring or event ring of an address translation unit. The ring holds a power-of-two number of entries chosen at run time. Each pointer has two parts. The low bits are the slot index. The bit just above the index is a wrap flag that flips each time the pointer passes the end of the ring. Comparing the two pointers gives the full and empty flags without any separate counter.

Software reads and writes the pointers, the ring size and the ring base address over a small register bus. Two strobes advance the pointers. The block also outputs the byte address of the slot that each pointer currently names. The consumer register holds a 7-bit error code next to the pointer, and an advance must leave that code unchanged. A separate port loads the error code without touching the pointer. An advance that would overrun or underrun the ring is dropped, and a sticky flag records it.

Top module: `qptr_unit`

## Requirements
- R1: After reset, both pointers, the size exponent L, the base and the error code are zero. Empty reads 1, full reads 0 and the misuse flag reads 0.
- R2: Empty is 1 when the producer and consumer are equal on bits [L:0]. Full is 1 when they have the same index bits [L-1:0] and different wrap bits at bit L. Full and empty are never 1 together.
- R3: A producer advance adds one to the producer and keeps only bits [L:0]. When the index rolls over, the wrap bit flips.
- R4: A consumer advance adds one within bits [L:0] only. The error code in bits [30:24] of the consumer register and every other upper bit stay as they were.
- R5: A producer advance while full, or a consumer advance while empty, does not change the pointer. Instead it sets the misuse flag. The misuse flag stays set until reset.
- R6: Each entry address is the base with its low 6 bits cleared, plus ENTRY_BYTES (default 16) times the pointer index masked to bits [L-1:0].
- R7: A write to the size register (address 2) changes L only while q_enable is 0. A written value above 19 (MAX_LOG2) is stored as 19.
- R8: When err_wr is 1, err_code is loaded into consumer bits [30:24] and the pointer bits do not change. The codes are: 0 no error, 1 illegal command, 2 abort, 3 sync error during invalidation.
- R9: Register map:
  - address 0 is the producer, bits [19:0];
  - address 1 is the consumer, pointer in bits [19:0] and error in bits [30:24];
  - address 2 is L;
  - address 3 is base bits [31:0];
  - address 4 is base bits [47:32].

  A pointer write is masked to bits [L:0] when it is stored. A register write to a pointer takes priority over an advance or an error-port write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| q_enable | input | 1 | Queue in use; blocks size changes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| err_wr | input | 1 | Load the consumer error code |
| err_code | input | 7 | Error code to load |
| prod_adv | input | 1 | Advance the producer |
| cons_adv | input | 1 | Advance the consumer |
| full | output | 1 | Ring is full |
| empty | output | 1 | Ring is empty |
| prod_addr | output | 48 | Byte address of the producer slot |
| cons_addr | output | 48 | Byte address of the consumer slot |
| misuse | output | 1 | Sticky overrun/underrun flag |

## Verification
The assertions check, on every cycle:
- full and empty are never 1 together;
- a dropped producer advance leaves the pointer unchanged and raises misuse, and misuse stays set;
- a consumer advance keeps the error code, and an error-port load keeps the pointer;
- the size is frozen while the queue is enabled;
- both entry addresses are aligned to the entry size.

Only the bench scenarios can show the exact arithmetic:
- the wrap bit flipping at rollover for each ring size;
- clamping of oversized size writes;
- the address offsets;
- the priority of register writes over strobes.

The bench checks these against a model built from the requirements.

// File: rtl/qptr_pkg.sv
package qptr_pkg;
    typedef enum logic [2:0] {
        RA_PROD    = 3'd0,
        RA_CONS    = 3'd1,
        RA_SIZE    = 3'd2,
        RA_BASE_LO = 3'd3,
        RA_BASE_HI = 3'd4
    } qreg_addr_e;

    typedef enum logic [6:0] {
        QERR_NONE    = 7'd0,
        QERR_ILLEGAL = 7'd1,
        QERR_ABORT   = 7'd2,
        QERR_SYNC    = 7'd3
    } qerr_e;

    localparam int ERR_LSB     = 24;
    localparam int ERR_W       = 7;
    localparam int ALIGN_BITS  = 6;
endpackage

// File: rtl/qptr_masks.sv
module qptr_masks #(
    parameter int PW = 20,
    parameter int LW = 5
) (
    input  logic [LW-1:0] log2,
    output logic [PW-1:0] idx_mask,
    output logic [PW-1:0] wrap_bit,
    output logic [PW-1:0] wi_mask
);
    for (genvar g = 0; g < PW; g++) begin : g_bit
        assign idx_mask[g] = (LW'(g) < log2);
        assign wrap_bit[g] = (LW'(g) == log2);
    end
    assign wi_mask = idx_mask | wrap_bit;
endmodule

// File: rtl/qptr_cmp.sv
module qptr_cmp #(
    parameter int PW = 20
) (
    input  logic [PW-1:0] prod,
    input  logic [PW-1:0] cons,
    input  logic [PW-1:0] wi_mask,
    input  logic [PW-1:0] wrap_bit,
    output logic          full,
    output logic          empty
);
    logic [PW-1:0] diff;
    assign diff  = (prod ^ cons) & wi_mask;
    assign full  = (diff == wrap_bit);
    assign empty = (diff == '0);
endmodule

// File: rtl/qptr_addr.sv
module qptr_addr #(
    parameter int PW          = 20,
    parameter int ADDR_W      = 48,
    parameter int ENTRY_SHIFT = 4,
    parameter int ALIGN       = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PW-1:0]     ptr,
    input  logic [PW-1:0]     idx_mask,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN) - 64'd1);
    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] offset;
    assign base_al = base & ~LOW_MASK;
    assign offset  = ADDR_W'(ptr & idx_mask) << ENTRY_SHIFT;
    assign addr    = base_al + offset;
endmodule

// File: rtl/qptr_unit.sv
module qptr_unit #(
    parameter int MAX_LOG2    = 19,
    parameter int ADDR_W      = 48,
    parameter int ENTRY_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_wr,
    input  logic [6:0]        err_code,
    input  logic              prod_adv,
    input  logic              cons_adv,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] prod_addr,
    output logic [ADDR_W-1:0] cons_addr,
    output logic              misuse
);
    import qptr_pkg::*;

    localparam int PW          = MAX_LOG2 + 1;
    localparam int LW          = $clog2(MAX_LOG2 + 1);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int BHI_W       = ADDR_W - 32;

    typedef struct packed {
        logic [PW-1:0]     prod;
        logic [PW-1:0]     cons;
        logic [ERR_W-1:0]  err;
        logic [LW-1:0]     log2;
        logic [ADDR_W-1:0] base;
        logic              misuse;
    } state_t;

    state_t q, d;

    logic [PW-1:0] idx_mask, wrap_bit, wi_mask;
    logic prod_wr, cons_wr, size_wr, blo_wr, bhi_wr;

    qptr_masks #(.PW(PW), .LW(LW)) u_masks (
        .log2(q.log2), .idx_mask(idx_mask), .wrap_bit(wrap_bit), .wi_mask(wi_mask)
    );

    qptr_cmp #(.PW(PW)) u_cmp (
        .prod(q.prod), .cons(q.cons), .wi_mask(wi_mask), .wrap_bit(wrap_bit),
        .full(full), .empty(empty)
    );

    qptr_addr #(.PW(PW), .ADDR_W(ADDR_W), .ENTRY_SHIFT(ENTRY_SHIFT), .ALIGN(ALIGN_BITS)) u_paddr (
        .base(q.base), .ptr(q.prod), .idx_mask(idx_mask), .addr(prod_addr)
    );

    qptr_addr #(.PW(PW), .ADDR_W(ADDR_W), .ENTRY_SHIFT(ENTRY_SHIFT), .ALIGN(ALIGN_BITS)) u_caddr (
        .base(q.base), .ptr(q.cons), .idx_mask(idx_mask), .addr(cons_addr)
    );

    assign prod_wr = reg_wr && (reg_addr == RA_PROD);
    assign cons_wr = reg_wr && (reg_addr == RA_CONS);
    assign size_wr = reg_wr && (reg_addr == RA_SIZE);
    assign blo_wr  = reg_wr && (reg_addr == RA_BASE_LO);
    assign bhi_wr  = reg_wr && (reg_addr == RA_BASE_HI);

    always_comb begin
        d = q;
        // producer: software write wins over the strobe
        if (prod_wr) begin
            d.prod = reg_wdata[PW-1:0] & wi_mask;
        end else if (prod_adv) begin
            if (full) d.misuse = 1'b1;
            else      d.prod   = (q.prod + PW'(1)) & wi_mask;
        end
        // consumer: increment confined to index and wrap bits
        if (cons_wr) begin
            d.cons = reg_wdata[PW-1:0] & wi_mask;
            d.err  = reg_wdata[ERR_LSB +: ERR_W];
        end else begin
            if (err_wr) d.err = err_code;
            if (cons_adv) begin
                if (empty) d.misuse = 1'b1;
                else       d.cons   = (q.cons & ~wi_mask) | ((q.cons + PW'(1)) & wi_mask);
            end
        end
        if (size_wr && !q_enable) begin
            d.log2 = (reg_wdata > 32'(MAX_LOG2)) ? LW'(MAX_LOG2) : reg_wdata[LW-1:0];
        end
        if (blo_wr) d.base[31:0]       = reg_wdata;
        if (bhi_wr) d.base[ADDR_W-1:32] = reg_wdata[BHI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_PROD:    reg_rdata = 32'(q.prod);
            RA_CONS:    reg_rdata = 32'(q.cons) | (32'(q.err) << ERR_LSB);
            RA_SIZE:    reg_rdata = 32'(q.log2);
            RA_BASE_LO: reg_rdata = q.base[31:0];
            RA_BASE_HI: reg_rdata = 32'(q.base[ADDR_W-1:32]);
            default:    reg_rdata = '0;
        endcase
    end

    assign misuse = q.misuse;

    // R2: the two flags exclude each other
    a_r2_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R5: a producer strobe on a full ring is dropped and flagged
    a_r5_prod_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && prod_adv && !prod_wr) |=> ($stable(q.prod) && misuse));

    // R5: a consumer strobe on an empty ring is dropped and flagged
    a_r5_cons_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && cons_adv && !cons_wr) |=> ($stable(q.cons) && misuse));

    // R5: misuse is sticky
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        misuse |=> misuse);

    // R4: consumer advance keeps the error code
    a_r4_err_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_adv && !err_wr && !cons_wr) |=> $stable(q.err));

    // R8: error load keeps the consumer pointer
    a_r8_ptr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr && !cons_adv && !cons_wr) |=> $stable(q.cons));

    // R7: size frozen while the queue is enabled
    a_r7_size_lock: assert property (@(posedge clk) disable iff (!rst_n)
        q_enable |=> $stable(q.log2));

    // R6: entry addresses aligned to the entry size
    a_r6_align: assert property (@(posedge clk) disable iff (!rst_n)
        ((prod_addr % ADDR_W'(ENTRY_BYTES)) == '0) && ((cons_addr % ADDR_W'(ENTRY_BYTES)) == '0));
endmodule

// File: tb/sim_qptr_unit.sv
module sim_qptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_enable = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        err_wr = 1'b0;
    logic [6:0]  err_code = 7'd0;
    logic        prod_adv = 1'b0;
    logic        cons_adv = 1'b0;
    logic        full, empty, misuse;
    logic [47:0] prod_addr, cons_addr;

    int tests = 0;
    int fails = 0;

    longint m_prod, m_cons, m_err, m_log2, m_base;
    bit     m_mis;

    always #5 clk = ~clk;

    qptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_wr(err_wr), .err_code(err_code), .prod_adv(prod_adv), .cons_adv(cons_adv),
        .full(full), .empty(empty), .prod_addr(prod_addr), .cons_addr(cons_addr),
        .misuse(misuse)
    );

    function automatic longint wim(longint l);
        return (longint'(1) << (l + 1)) - 1;
    endfunction
    function automatic bit f_empty();
        return ((m_prod ^ m_cons) & wim(m_log2)) == 0;
    endfunction
    function automatic bit f_full();
        return ((m_prod ^ m_cons) & wim(m_log2)) == (longint'(1) << m_log2);
    endfunction
    function automatic longint f_addr(longint p);
        longint idx = p & ((longint'(1) << m_log2) - 1);
        return ((m_base & ~longint'(63)) + (idx << 4)) & ((longint'(1) << 48) - 1);
    endfunction
    function automatic longint f_read(int a);
        case (a)
            0: return m_prod;
            1: return m_cons | (m_err << 24);
            2: return m_log2;
            3: return m_base & 64'hFFFF_FFFF;
            4: return (m_base >> 32) & 64'hFFFF;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prod = 0; m_cons = 0; m_err = 0; m_log2 = 0; m_base = 0; m_mis = 0;
    endtask

    task automatic step(bit wr, int a, logic [31:0] wd, bit ew, int ec, bit pa, bit ca, bit en);
        bit fu, em;
        longint w;
        reg_wr = wr; reg_addr = 3'(a); reg_wdata = wd; err_wr = ew; err_code = 7'(ec);
        prod_adv = pa; cons_adv = ca; q_enable = en;
        fu = f_full(); em = f_empty(); w = wim(m_log2);
        @(posedge clk);
        if (wr && a == 0) m_prod = longint'(wd) & w;
        else if (pa) begin
            if (fu) m_mis = 1; else m_prod = (m_prod + 1) & w;
        end
        if (wr && a == 1) begin
            m_cons = longint'(wd) & w & 64'hF_FFFF;
            m_err  = (longint'(wd) >> 24) & 7'h7F;
        end else begin
            if (ew) m_err = ec;
            if (ca) begin
                if (em) m_mis = 1; else m_cons = (m_cons & ~w) | ((m_cons + 1) & w);
            end
        end
        if (wr && a == 2 && !en) m_log2 = (wd > 19) ? 19 : longint'(wd);
        if (wr && a == 3) m_base = (m_base & ~longint'(64'hFFFF_FFFF)) | longint'(wd);
        if (wr && a == 4) m_base = (m_base & 64'hFFFF_FFFF) | ((longint'(wd) & 16'hFFFF) << 32);
        #1;
        chk("R2 full", full, f_full());
        chk("R2 empty", empty, f_empty());
        chk("R6 prod_addr", prod_addr, f_addr(m_prod));
        chk("R6 cons_addr", cons_addr, f_addr(m_cons));
        chk("R5 misuse", misuse, m_mis);
        chk("R9 rdata", reg_rdata, f_read(a));
        reg_wr = 0; err_wr = 0; prod_adv = 0; cons_adv = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        reg_wr = 0; err_wr = 0; prod_adv = 0; cons_adv = 0; q_enable = 0;
        repeat (2) @(posedge clk);
        model_reset();
        #1 rst_n = 1;
    endtask

    task automatic rd(int a);
        step(0, a, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset state
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 misuse", misuse, 0);
        rd(0); chk("R1 prod", reg_rdata, 0);
        rd(1); chk("R1 cons", reg_rdata, 0);
        rd(2); chk("R1 size", reg_rdata, 0);

        // R7: clamp and lock
        step(1, 2, 32'd25, 0, 0, 0, 0, 0); chk("R7 clamp", reg_rdata, 19);
        step(1, 2, 32'd2, 0, 0, 0, 0, 1);  chk("R7 locked", reg_rdata, 19);
        step(1, 2, 32'd2, 0, 0, 0, 0, 0);  chk("R7 set", reg_rdata, 2);

        // R6: base alignment
        step(1, 3, 32'h0000_10FF, 0, 0, 0, 0, 1);
        step(1, 4, 32'h0000_0001, 0, 0, 0, 0, 1);
        chk("R6 base", prod_addr, 48'h1_0000_10C0);

        // R3: fill a 4-entry ring, wrap bit flips
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0, 1);
        chk("R3 wrap", reg_rdata, 4);
        chk("R2 full", full, 1);
        chk("R3 addr", prod_addr, 48'h1_0000_10C0);
        // R5: overrun dropped
        step(0, 0, 0, 0, 0, 1, 0, 1);
        chk("R5 prod held", reg_rdata, 4);
        chk("R5 flag", misuse, 1);

        // R8: error load keeps pointer
        step(0, 1, 0, 1, 2, 0, 0, 1); chk("R8 err", reg_rdata, 32'h0200_0000);
        // R4: consumer advance keeps error
        step(0, 1, 0, 0, 0, 0, 1, 1); chk("R4 adv", reg_rdata, 32'h0200_0001);
        chk("R6 cons step", cons_addr, 48'h1_0000_10D0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 1, 1);
        chk("R4 wrap", reg_rdata, 32'h0200_0004);
        chk("R2 empty", empty, 1);
        step(0, 1, 0, 0, 0, 0, 1, 1); chk("R5 cons held", reg_rdata, 32'h0200_0004);

        // R9: masking and write priority over strobe
        step(1, 0, 32'hFFFF_FFFD, 0, 0, 1, 0, 1); chk("R9 prio", reg_rdata, 5);

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            step(1, 2, 32'(ph % 3 + 1), 0, 0, 0, 0, 0);
            step(1, 3, $urandom, 0, 0, 0, 0, 0);
            for (int n = 0; n < 600; n++) begin
                int a;
                logic [31:0] wd;
                bit wr, pa, ca;
                wr = ($urandom % 100) < 8;
                a  = $urandom % 5;
                wd = $urandom;
                if (a == 2 && ($urandom % 4) != 0) wd = $urandom % 5;
                pa = ($urandom % 100) < ((ph % 2) ? 60 : 35);
                ca = ($urandom % 100) < ((ph % 2) ? 35 : 60);
                step(wr, a, wd, ($urandom % 100) < 5, $urandom % 4, pa, ca, $urandom % 2);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule